// File: doc/BRIEF.md
# Dual-Mode Twisted-Ring / Pseudo-Random Counter

This block is a four-bit state register with two stepping rules, chosen by a mode input. In twisted-ring mode the register moves through the eight-state Johnson sequence. In pseudo-random mode it acts as a maximal-length linear feedback shift register. That mode visits every nonzero four-bit value once in a fixed order and never reaches zero. Both rules use one shift chain. On each step every bit moves one place toward the least significant stage, and only the bit fed into the most significant stage depends on the mode.

A synchronous clear loads a start value that depends on the mode. If pseudo-random mode is selected while the register holds zero, the register steps out of that state. A mode change does not disturb the stored value; it only picks the rule used on the next clock edge. The output comes straight from the state flops.

Top module: `mixmode_counter`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `q` becomes 0000 on that edge, whatever `clr` and `mode` are.
- R2: With `rst` 0, `clr` 1 and `mode` 0 (twisted-ring), `q` becomes 0000 on the edge.
- R3: With `rst` 0, `clr` 1 and `mode` 1 (pseudo-random), `q` becomes 0001 on the edge.
- R4: On a step (`rst` 0, `clr` 0, and not the zero-escape case of R7), the new `q[2:0]` equals the old `q[3:1]`, so bits move toward `q[0]`.
- R5: On a twisted-ring step, the new `q[3]` is the inverse of the old `q[0]`. From 0000 the hex sequence is 0, 8, C, E, F, 7, 3, 1, and then it returns to 0.
- R6: On a pseudo-random step from a nonzero state, the new `q[3]` is old `q[3]` XOR old `q[0]`. From 1 the hex sequence is 1, 8, C, E, F, 7, B, 5, A, D, 6, 3, 9, 4, 2, and then it returns to 1, a period of 15.
- R7: On a pseudo-random step from 0000, `q` becomes 0001. After any edge with `rst` 0 and `mode` 1, `q` is nonzero.
- R8: A change of `mode` leaves `q` as it is. The next edge applies the newly selected rule to the current `q`.
- R9: `rst` takes priority over `clr`, and `clr` takes priority over stepping in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to 0000 |
| clr | input | 1 | Synchronous clear to the start value of the selected mode |
| mode | input | 1 | 0 = twisted-ring, 1 = pseudo-random |
| q | output | 4 | Registered state, q[3] is the head stage |

## Verification
The assertions check on every cycle the values a clear loads in each mode, the one-place shift toward `q[0]`, the feedback bit of each mode, and that pseudo-random mode never leaves the register at zero. Only the bench scenarios can show that the two feedback rules give the whole ordered eight-state and fifteen-state cycles. The same holds for a mid-sequence mode switch continuing from the stored value and for the escape from zero in practice.

// File: rtl/mixmode_pkg.sv
package mixmode_pkg;
  typedef enum logic {
    MODE_TWIST = 1'b0,
    MODE_PRNG  = 1'b1
  } step_mode_e;
endpackage

// File: rtl/twist_step.sv
module twist_step #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  localparam int HEAD = WIDTH - 1;

  always_comb begin
    nxt             = cur >> 1;
    nxt[HEAD]       = ~cur[0];
  end
endmodule

// File: rtl/prng_step.sv
module prng_step #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  localparam int              HEAD   = WIDTH - 1;
  localparam logic [WIDTH-1:0] ESCAPE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic stuck;

  always_comb begin
    stuck = (cur == '0);
    if (stuck) begin
      nxt = ESCAPE;
    end else begin
      nxt       = cur >> 1;
      nxt[HEAD] = cur[HEAD] ^ cur[0];
    end
  end
endmodule

// File: rtl/mixmode_counter.sv
module mixmode_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             mode,
  output logic [WIDTH-1:0] q
);
  import mixmode_pkg::*;

  localparam logic [WIDTH-1:0] TWIST_START = '0;
  localparam logic [WIDTH-1:0] PRNG_START  = {{(WIDTH-1){1'b0}}, 1'b1};

  step_mode_e       sel;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] twist_nxt;
  logic [WIDTH-1:0] prng_nxt;
  logic [WIDTH-1:0] state_d;

  assign sel = step_mode_e'(mode);

  twist_step #(.WIDTH(WIDTH)) u_twist (
    .cur (state_q),
    .nxt (twist_nxt)
  );

  prng_step #(.WIDTH(WIDTH)) u_prng (
    .cur (state_q),
    .nxt (prng_nxt)
  );

  always_comb begin
    unique case (sel)
      MODE_PRNG:  state_d = clr ? PRNG_START  : prng_nxt;
      default:    state_d = clr ? TWIST_START : twist_nxt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign q = state_q;
endmodule

// File: rtl/mixmode_counter_chk.sv
module mixmode_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             mode,
  input logic [WIDTH-1:0] q
);
  localparam int HEAD = WIDTH - 1;

  p_clear_twist_r2: assert property (@(posedge clk) disable iff (rst)
    (clr && !mode) |=> (q == '0));

  p_clear_prng_r3: assert property (@(posedge clk) disable iff (rst)
    (clr && mode) |=> (q == {{(WIDTH-1){1'b0}}, 1'b1}));

  p_shift_dir_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(mode && q == '0)) |=> (q[HEAD-1:0] == $past(q[HEAD:1])));

  p_twist_head_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !mode) |=> (q[HEAD] == !$past(q[0])));

  p_prng_head_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && mode && q != '0) |=> (q[HEAD] == ($past(q[HEAD]) ^ $past(q[0]))));

  p_no_lockup_r7: assert property (@(posedge clk) disable iff (rst)
    mode |=> (q != '0));
endmodule

bind mixmode_counter mixmode_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .clr  (clr),
  .mode (mode),
  .q    (q)
);

// File: tb/tb_mixmode_counter.sv
module tb_mixmode_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       mode = 1'b0;
  logic [3:0] q;

  int runs  = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  mixmode_counter #(.WIDTH(4)) dut (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .mode (mode),
    .q    (q)
  );

  // Entry: {clr, mode, expected q after the edge, requirement number}
  localparam int NV = 31;
  localparam logic [9:0] VEC [NV] = '{
    // R5 twisted-ring cycle from 0000
    {1'b0,1'b0,4'h8,4'd5}, {1'b0,1'b0,4'hC,4'd5}, {1'b0,1'b0,4'hE,4'd5},
    {1'b0,1'b0,4'hF,4'd5}, {1'b0,1'b0,4'h7,4'd5}, {1'b0,1'b0,4'h3,4'd5},
    {1'b0,1'b0,4'h1,4'd5}, {1'b0,1'b0,4'h0,4'd5},
    // R2 clear in twisted-ring mode
    {1'b1,1'b0,4'h0,4'd2},
    // R7 escape from zero
    {1'b0,1'b1,4'h1,4'd7},
    // R6 full pseudo-random cycle
    {1'b0,1'b1,4'h8,4'd6}, {1'b0,1'b1,4'hC,4'd6}, {1'b0,1'b1,4'hE,4'd6},
    {1'b0,1'b1,4'hF,4'd6}, {1'b0,1'b1,4'h7,4'd6}, {1'b0,1'b1,4'hB,4'd6},
    {1'b0,1'b1,4'h5,4'd6}, {1'b0,1'b1,4'hA,4'd6}, {1'b0,1'b1,4'hD,4'd6},
    {1'b0,1'b1,4'h6,4'd6}, {1'b0,1'b1,4'h3,4'd6}, {1'b0,1'b1,4'h9,4'd6},
    {1'b0,1'b1,4'h4,4'd6}, {1'b0,1'b1,4'h2,4'd6}, {1'b0,1'b1,4'h1,4'd6},
    // R8 mode switches mid-sequence
    {1'b0,1'b1,4'h8,4'd8}, {1'b0,1'b1,4'hC,4'd8},
    {1'b0,1'b0,4'hE,4'd8}, {1'b0,1'b1,4'hF,4'd8},
    // R3 clear in pseudo-random mode, then R9 clear over stepping
    {1'b1,1'b1,4'h1,4'd3}, {1'b1,1'b0,4'h0,4'd9}
  };

  task automatic check(input logic [3:0] exp, input string req);
    runs++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s: q=%h expected %h", req, q, exp);
    end
  endtask

  task automatic step(input logic c, input logic m);
    clr  = c;
    mode = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(4'h0, "R1 reset state");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9], VEC[i][8]);
      check(VEC[i][7:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
    end

    // R4 / R8: twisted-ring from a pseudo-random state (5 -> 2)
    step(1'b1, 1'b1);           // q = 1
    step(1'b0, 1'b1);           // 8
    step(1'b0, 1'b1);           // C
    step(1'b0, 1'b1);           // E
    step(1'b0, 1'b1);           // F
    step(1'b0, 1'b1);           // 7
    step(1'b0, 1'b1);           // B
    step(1'b0, 1'b1);           // 5
    check(4'h5, "R6 walk to 5");
    step(1'b0, 1'b0);
    check(4'h2, "R4 twist step from 5");

    // R1 / R9: reset wins over clear in pseudo-random mode
    rst = 1'b1;
    step(1'b1, 1'b1);
    check(4'h0, "R9 reset over clear");
    rst = 1'b0;
    step(1'b0, 1'b1);
    check(4'h1, "R7 escape after reset");

    // R1: reset from a nonzero state
    step(1'b0, 1'b1);           // 8
    rst = 1'b1;
    step(1'b0, 1'b0);
    check(4'h0, "R1 reset from nonzero");
    rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog: q=%h expected completion", q);
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule